// File: doc/BRIEF.md
# Boundary-Scan Cell Chain

This block is a serial chain of boundary-scan cells that sits between a chip's core logic and its pins. Each cell has two parts. A capture/shift flop is clocked on the rising test-clock edge. A slave (update) flop is clocked on the falling edge. The test controller, which is not part of this block, supplies the capture, shift and update strobes and a two-bit mode code. The chain can take a snapshot of the pin inputs and core outputs. It can move data serially from the test data input to the test data output. It can also hold values in the slave stage, which then drive the pins and the core inputs under test.

Input-pin cells sit nearest the serial input, so they occupy the high chain bits. Output-pin cells sit nearest the serial output, so they occupy the low chain bits. In normal operation and during a non-intrusive snapshot, the pins and core inputs carry live system values. In the two driving modes, they carry the slave contents. These change only on a falling test-clock edge.

Top module: `bsc_chain`

## Requirements
- R1: An active-low asynchronous test reset (`trst_n` low) clears every capture/shift cell and every slave cell to 0.
- R2: On a rising `tck` edge with `shift_dr` high and `capture_dr` low, every chain bit moves one place toward bit 0, and `tdi` enters the top bit without inversion. `tdo` always shows chain bit 0.
- R3: On a rising `tck` edge with `capture_dr` high, `pin_in[i]` is loaded into chain bit N_OUT+i and `core_out[j]` is loaded into chain bit j. This happens in every mode.
- R4: When `capture_dr` and `shift_dr` are both high on the same rising edge, the capture takes place and no shift occurs.
- R5: On a rising edge with neither `capture_dr` nor `shift_dr` high, the chain keeps its contents.
- R6: On a falling `tck` edge with `update_dr` high, the whole chain is copied into the slave cells. With `update_dr` low, the slave cells keep their values.
- R7: `mode` is encoded as 2'b00 normal, 2'b01 sample, 2'b10 extest and 2'b11 clamp. In normal and sample, `pin_out` equals `core_out` and `core_in` equals `pin_in`.
- R8: In extest and clamp, `pin_out[j]` equals slave bit j and `core_in[i]` equals slave bit N_OUT+i. With the mode held, these outputs change only on a falling edge on which an update occurs.
- R9: In normal and sample modes, capture, shift and update activity has no effect on `pin_out` or `core_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tdi | input | 1 | Serial test data in |
| capture_dr | input | 1 | Capture strobe, sampled on rising edge |
| shift_dr | input | 1 | Shift strobe, sampled on rising edge |
| update_dr | input | 1 | Update strobe, sampled on falling edge |
| mode | input | 2 | Mode code (normal, sample, extest, clamp) |
| core_out | input | N_OUT | Values the core wants on the output pins |
| pin_in | input | N_IN | Values arriving at the input pins |
| tdo | output | 1 | Serial test data out (chain bit 0) |
| pin_out | output | N_OUT | Values driven toward the output pins |
| core_in | output | N_IN | Values presented to the core inputs |

## Verification
Capture and shift can both be requested on the same rising edge. An update can also land on the falling edge of a cycle in which the chain shifted or captured. The bench forces the capture/shift collision with fixed patterns and then clocks the whole chain out through `tdo`, so any shift that should have been suppressed shows up. The random phase asserts all three strobes freely in every mode, and a reference model compares `tdo`, `pin_out` and `core_in` after each falling edge.

// File: rtl/bsc_pkg.sv
package bsc_pkg;
    typedef enum logic [1:0] {
        BSC_NORMAL = 2'b00,
        BSC_SAMPLE = 2'b01,
        BSC_EXTEST = 2'b10,
        BSC_CLAMP  = 2'b11
    } bsc_mode_e;

    function automatic logic bsc_drives(input logic [1:0] m);
        return (m == BSC_EXTEST) || (m == BSC_CLAMP);
    endfunction
endpackage

// File: rtl/bsc_shift_stage.sv
module bsc_shift_stage #(
    parameter int N_IN  = 4,
    parameter int N_OUT = 6,
    localparam int CH   = N_IN + N_OUT
) (
    input  logic             tck,
    input  logic             trst_n,
    input  logic             tdi,
    input  logic             capture_dr,
    input  logic             shift_dr,
    input  logic [N_IN-1:0]  pin_in,
    input  logic [N_OUT-1:0] core_out,
    output logic [CH-1:0]    sh
);
    typedef struct packed {
        logic [CH-1:0] cells;
    } shift_st_t;

    shift_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (capture_dr) begin
            st_d.cells = {pin_in, core_out};
        end else if (shift_dr) begin
            st_d.cells = {tdi, st_q.cells[CH-1:1]};
        end
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) st_q <= '0;
        else         st_q <= st_d;
    end

    assign sh = st_q.cells;
endmodule

// File: rtl/bsc_update_stage.sv
module bsc_update_stage #(
    parameter int W = 10
) (
    input  logic         tck,
    input  logic         trst_n,
    input  logic         update_dr,
    input  logic [W-1:0] sh,
    output logic [W-1:0] upd
);
    typedef struct packed {
        logic [W-1:0] slave;
    } upd_st_t;

    upd_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (update_dr) st_d.slave = sh;
    end

    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) st_q <= '0;
        else         st_q <= st_d;
    end

    assign upd = st_q.slave;
endmodule

// File: rtl/bsc_pin_mux.sv
module bsc_pin_mux
    import bsc_pkg::*;
#(
    parameter int N_IN  = 4,
    parameter int N_OUT = 6,
    localparam int CH   = N_IN + N_OUT
) (
    input  logic [1:0]       mode,
    input  logic [CH-1:0]    upd,
    input  logic [N_OUT-1:0] core_out,
    input  logic [N_IN-1:0]  pin_in,
    output logic [N_OUT-1:0] pin_out,
    output logic [N_IN-1:0]  core_in
);
    logic drive;

    always_comb begin
        drive = bsc_drives(mode);
        for (int j = 0; j < N_OUT; j++) begin
            pin_out[j] = drive ? upd[j] : core_out[j];
        end
        for (int i = 0; i < N_IN; i++) begin
            core_in[i] = drive ? upd[N_OUT+i] : pin_in[i];
        end
    end
endmodule

// File: rtl/bsc_chain.sv
module bsc_chain #(
    parameter int N_IN  = 4,
    parameter int N_OUT = 6,
    localparam int CH   = N_IN + N_OUT
) (
    input  logic             tck,
    input  logic             trst_n,
    input  logic             tdi,
    input  logic             capture_dr,
    input  logic             shift_dr,
    input  logic             update_dr,
    input  logic [1:0]       mode,
    input  logic [N_OUT-1:0] core_out,
    input  logic [N_IN-1:0]  pin_in,
    output logic             tdo,
    output logic [N_OUT-1:0] pin_out,
    output logic [N_IN-1:0]  core_in
);
    logic [CH-1:0] sh_q;
    logic [CH-1:0] upd_q;

    bsc_shift_stage #(.N_IN(N_IN), .N_OUT(N_OUT)) u_shift (
        .tck(tck), .trst_n(trst_n), .tdi(tdi),
        .capture_dr(capture_dr), .shift_dr(shift_dr),
        .pin_in(pin_in), .core_out(core_out), .sh(sh_q)
    );

    bsc_update_stage #(.W(CH)) u_upd (
        .tck(tck), .trst_n(trst_n), .update_dr(update_dr),
        .sh(sh_q), .upd(upd_q)
    );

    bsc_pin_mux #(.N_IN(N_IN), .N_OUT(N_OUT)) u_mux (
        .mode(mode), .upd(upd_q), .core_out(core_out), .pin_in(pin_in),
        .pin_out(pin_out), .core_in(core_in)
    );

    assign tdo = sh_q[0];
endmodule

// File: rtl/bsc_chain_chk.sv
module bsc_chain_chk #(
    parameter int N_IN  = 4,
    parameter int N_OUT = 6,
    localparam int CH   = N_IN + N_OUT
) (
    input logic             tck,
    input logic             trst_n,
    input logic             tdi,
    input logic             capture_dr,
    input logic             shift_dr,
    input logic             update_dr,
    input logic [1:0]       mode,
    input logic [N_OUT-1:0] core_out,
    input logic [N_IN-1:0]  pin_in,
    input logic [N_OUT-1:0] pin_out,
    input logic [N_IN-1:0]  core_in,
    input logic [CH-1:0]    sh_q,
    input logic [CH-1:0]    upd_q
);
    logic drive;
    assign drive = mode[1];

    // R2
    a_r2_shift: assert property (@(posedge tck) disable iff (!trst_n)
        (shift_dr && !capture_dr) |=>
            (sh_q[CH-1] == $past(tdi)) && (sh_q[CH-2:0] == $past(sh_q[CH-1:1])));

    // R3 and R4
    a_r3_capture: assert property (@(posedge tck) disable iff (!trst_n)
        capture_dr |=> sh_q == {$past(pin_in), $past(core_out)});

    // R5
    a_r5_hold: assert property (@(posedge tck) disable iff (!trst_n)
        (!capture_dr && !shift_dr) |=> $stable(sh_q));

    // R6
    a_r6_update: assert property (@(negedge tck) disable iff (!trst_n)
        update_dr |=> upd_q == $past(sh_q));

    // R6
    a_r6_keep: assert property (@(negedge tck) disable iff (!trst_n)
        !update_dr |=> $stable(upd_q));

    // R8
    a_r8_pins_hold: assert property (@(negedge tck) disable iff (!trst_n)
        (drive && $past(drive) && !$past(update_dr)) |->
            ($stable(pin_out) && $stable(core_in)));

    // R7 and R9
    a_r7_pass: assert property (@(posedge tck) disable iff (!trst_n)
        !drive |-> (pin_out == core_out) && (core_in == pin_in));
endmodule

bind bsc_chain bsc_chain_chk #(.N_IN(N_IN), .N_OUT(N_OUT)) u_chk (
    .tck(tck), .trst_n(trst_n), .tdi(tdi), .capture_dr(capture_dr),
    .shift_dr(shift_dr), .update_dr(update_dr), .mode(mode),
    .core_out(core_out), .pin_in(pin_in), .pin_out(pin_out),
    .core_in(core_in), .sh_q(sh_q), .upd_q(upd_q)
);

// File: tb/bsc_chain_tb.sv
module bsc_chain_tb;
    localparam int NI = 4;
    localparam int NO = 6;
    localparam int CH = NI + NO;

    logic tck = 1'b0;
    logic trst_n = 1'b0;
    logic tdi = 1'b0, capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0;
    logic [1:0] mode = 2'b00;
    logic [NO-1:0] core_out = '0;
    logic [NI-1:0] pin_in = '0;
    logic tdo;
    logic [NO-1:0] pin_out;
    logic [NI-1:0] core_in;

    int n_tests = 0;
    int n_fail = 0;
    logic [CH-1:0] m_sh = '0;
    logic [CH-1:0] m_upd = '0;
    logic done = 1'b0;

    always #4 tck = ~tck;

    bsc_chain #(.N_IN(NI), .N_OUT(NO)) u_dut (
        .tck(tck), .trst_n(trst_n), .tdi(tdi), .capture_dr(capture_dr),
        .shift_dr(shift_dr), .update_dr(update_dr), .mode(mode),
        .core_out(core_out), .pin_in(pin_in), .tdo(tdo),
        .pin_out(pin_out), .core_in(core_in)
    );

    function automatic logic [NO-1:0] exp_pin(input logic [1:0] m,
            input logic [CH-1:0] u, input logic [NO-1:0] c);
        return m[1] ? u[NO-1:0] : c;
    endfunction

    function automatic logic [NI-1:0] exp_core(input logic [1:0] m,
            input logic [CH-1:0] u, input logic [NI-1:0] p);
        return m[1] ? u[CH-1:NO] : p;
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive one cycle, advance model at both edges, check after falling edge
    task automatic cyc(input logic cap, input logic shf, input logic upd,
            input logic [1:0] md, input logic di, input logic [NI-1:0] p,
            input logic [NO-1:0] c, input string ttag, input string ptag);
        capture_dr = cap; shift_dr = shf; update_dr = upd;
        mode = md; tdi = di; pin_in = p; core_out = c;
        @(posedge tck);
        if (cap)      m_sh = {p, c};
        else if (shf) m_sh = {di, m_sh[CH-1:1]};
        @(negedge tck);
        if (upd) m_upd = m_sh;
        #2;
        check({ttag, " tdo"}, 16'(tdo), 16'(m_sh[0]));
        check({ptag, " pin_out"}, 16'(pin_out), 16'(exp_pin(md, m_upd, c)));
        check({ptag, " core_in"}, 16'(core_in), 16'(exp_core(md, m_upd, p)));
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed;
        seed = $urandom(32'd1234);
        core_out = 6'h2A; pin_in = 4'h5;
        repeat (3) @(negedge tck);
        #2;
        // R1: reset state at ports
        check("R1 tdo", 16'(tdo), 16'h0);
        check("R1 pin_out", 16'(pin_out), 16'h2A);
        check("R1 core_in", 16'(core_in), 16'h5);
        trst_n = 1'b1;
        // R1: slave cleared, visible in extest
        cyc(0, 0, 0, 2'b10, 0, 4'h5, 6'h2A, "R1", "R1");
        cyc(0, 0, 0, 2'b00, 0, 4'h5, 6'h2A, "R1", "R7");

        // R3: capture then shift the whole chain out
        cyc(1, 0, 0, 2'b01, 0, 4'hA, 6'h15, "R3", "R9");
        for (int k = 0; k < CH; k++) cyc(0, 1, 0, 2'b01, 1, 4'h3, 6'h0C, "R3", "R9");

        // R2: shift a pattern in, then R6: update in extest
        for (int k = 0; k < CH; k++) cyc(0, 1, 0, 2'b10, k[0] ^ k[2], 4'h0, 6'h3F, "R2", "R8");
        cyc(0, 0, 1, 2'b10, 0, 4'h0, 6'h3F, "R5", "R6");

        // R5 hold, R8 clamp keeps the pins steady
        for (int k = 0; k < 3; k++) cyc(0, 0, 0, 2'b11, 1, 4'h9, 6'h11, "R5", "R8");

        // R4: capture and shift together, then shift out
        cyc(1, 1, 0, 2'b00, 1, 4'hC, 6'h21, "R4", "R7");
        for (int k = 0; k < CH; k++) cyc(0, 1, 0, 2'b00, 0, 4'h1, 6'h02, "R4", "R7");

        // R9: activity in sample and normal leaves live paths alone
        cyc(1, 0, 1, 2'b01, 0, 4'h6, 6'h33, "R3", "R9");
        cyc(0, 1, 1, 2'b00, 1, 4'h7, 6'h1E, "R2", "R9");
        cyc(0, 0, 0, 2'b10, 0, 4'h7, 6'h1E, "R5", "R8");

        // Random phase
        for (int k = 0; k < 400; k++) begin
            logic [31:0] r;
            r = $urandom;
            cyc(r[0] & r[1] & r[2], r[3], r[4] & r[5], r[7:6], r[8],
                r[12:9], r[18:13], "R2", r[7] ? "R8" : "R7");
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule